// File: doc/BRIEF.md
# Magnitude and Phase-Locking Seizure Trigger

This block turns per-sample measurements from a two-channel neural processor into seizure alarms. On every sample tick it receives the band magnitudes of both channels and the phase-locking value (PLV) that quantifies how tightly the two channels' phases track each other. It compares them against programmable thresholds and raises up to three alarms: a magnitude alarm, a PLV alarm and a combined alarm.

The magnitude path fires when both channels are strong in the same sample. The PLV path does not look at single samples. It integrates the PLV over a window of 2^N ticks, where N is programmable, and fires when the integrated synchrony falls below its threshold. Each alarm, once raised, is held for a programmable number of ticks. That number is the sum of two period settings: the expected seizure occurrence period and the prediction horizon. The combined alarm is active only while both held alarms are active. Choosing thresholds and computing the PLV are done elsewhere.

Top module: `seizure_trigger`

## Requirements
- R1: On a tick, the magnitude detector triggers only if `mag_a` is strictly greater than `mag_a_thr` and `mag_b` is strictly greater than `mag_b_thr` in that same sample. Equality on either channel, or one channel alone above its threshold, does not trigger.
- R2: The PLV values of 2^`win_log2` consecutive ticks are summed, and the sum is compared when the last tick of the window arrives. The PLV detector triggers if the sum is strictly less than `plv_thr` shifted left by `win_log2`. The sum then restarts from zero. Ticks inside a window never trigger.
- R3: `comb_alarm` is high exactly while both `mag_alarm` and `plv_alarm` are high.
- R4: A trigger sets its alarm from the clock after the trigger tick. The alarm then stays high through D further ticks and falls on the D-th of them, where D = `sop_len` + `sph_len` (computed without wrap). When D is 0, no alarm is raised.
- R5: Clocks without `tick` change neither alarm, and no trigger takes place while `tick` is low, whatever the inputs.
- R6: A trigger that arrives while an alarm is held restarts that alarm's hold at the full D ticks.
- R7: Synchronous active-low `rst_n` clears all alarms, hold counters, the window sum and the window position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock pulse marking a new sample |
| mag_a | input | 10 | Band magnitude, channel A |
| mag_b | input | 10 | Band magnitude, channel B |
| plv | input | 10 | Phase-locking value, unsigned fraction (1023 is close to 1) |
| mag_a_thr | input | 10 | Magnitude threshold, channel A |
| mag_b_thr | input | 10 | Magnitude threshold, channel B |
| plv_thr | input | 10 | Per-sample PLV threshold |
| win_log2 | input | 3 | Log2 of the PLV window length in ticks |
| sop_len | input | 24 | Occurrence period, in ticks |
| sph_len | input | 24 | Prediction horizon, in ticks |
| mag_alarm | output | 1 | Held magnitude alarm |
| plv_alarm | output | 1 | Held PLV alarm |
| comb_alarm | output | 1 | Both held alarms active |

## Verification
A magnitude trigger and a PLV window completion can happen on the same tick. In that case both hold counters load together and the combined alarm rises in the same clock as the two individual alarms. The bench provokes this by placing strong magnitudes on the last tick of a low-PLV window. It checks that all three outputs go high on the next clock. It then retriggers only the magnitude path, so the two holds run out at different ticks, and it checks that the combined alarm falls exactly when the PLV hold ends.

// File: rtl/seizure_trig_pkg.sv
// Shared widths for the seizure trigger. All sizes are defaults that the
// top module passes down as parameters.
package seizure_trig_pkg;
    localparam int VAL_W_DEF    = 10;  // magnitude / PLV sample width
    localparam int HOLD_W_DEF   = 24;  // period setting width
    localparam int MAX_LOG2_DEF = 7;   // largest window exponent
    localparam int LOG2_W_DEF   = 3;   // width of the window exponent port

    localparam int NUM_DET = 2;        // detector paths: magnitude and PLV
    localparam int DET_MAG = 0;
    localparam int DET_PLV = 1;
endpackage

// File: rtl/dual_mag_compare.sv
// Dual-channel magnitude comparator.
// Raises trig for one tick when both channel magnitudes exceed their own
// thresholds. Assumes tick lasts one clock per sample.
module dual_mag_compare #(
    parameter int VAL_W = 10
) (
    input  logic             tick,
    input  logic [VAL_W-1:0] mag_a,
    input  logic [VAL_W-1:0] mag_b,
    input  logic [VAL_W-1:0] thr_a,
    input  logic [VAL_W-1:0] thr_b,
    output logic             trig
);
    logic above_a;
    logic above_b;

    // Strict comparisons per channel, qualified by the sample tick.
    always_comb begin
        above_a = mag_a > thr_a;
        above_b = mag_b > thr_b;
        trig    = tick && above_a && above_b;
    end
endmodule

// File: rtl/plv_window.sv
// PLV integrate-and-dump window.
// Sums PLV samples over 2^win_log2 ticks. On the closing tick of a window it
// compares the sum with plv_thr scaled by the window length, pulses trig when
// the sum is lower, and restarts. Assumes win_log2 <= MAX_LOG2. If win_log2
// shrinks in the middle of a window, that window closes on the next tick.
module plv_window #(
    parameter int VAL_W    = 10,
    parameter int MAX_LOG2 = 7,
    parameter int LOG2_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [VAL_W-1:0]  plv,
    input  logic [VAL_W-1:0]  plv_thr,
    input  logic [LOG2_W-1:0] win_log2,
    output logic              trig
);
    localparam int SUM_W = VAL_W + MAX_LOG2;
    localparam int CNT_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_next;
    logic [SUM_W-1:0] thr_scaled;
    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] last_pos;
    logic             closing;

    // Window bookkeeping: last index, scaled threshold and the sum including the current sample.
    always_comb begin
        last_pos   = CNT_W'((32'd1 << win_log2) - 32'd1);
        thr_scaled = SUM_W'(plv_thr) << win_log2;
        sum_next   = sum_q + SUM_W'(plv);
        closing    = tick && (pos_q >= last_pos);
        trig       = closing && (sum_next < thr_scaled);
    end

    // Accumulate within the window, dump at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            pos_q <= '0;
        end else if (tick) begin
            if (closing) begin
                sum_q <= '0;
                pos_q <= '0;
            end else begin
                sum_q <= sum_next;
                pos_q <= pos_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hold_timer.sv
// Retriggerable alarm hold timer.
// A trigger loads dur and each later tick counts down. active is high while
// the count is nonzero. Assumes trig is only ever high together with tick.
module hold_timer #(
    parameter int DUR_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trig,
    input  logic [DUR_W-1:0] dur,
    output logic             active
);
    logic [DUR_W-1:0] left_q;

    // Load on trigger, count down one per tick, hold without tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (tick) begin
            if (trig) begin
                left_q <= dur;
            end else if (left_q != '0) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    // Alarm reflects a pending hold.
    always_comb active = (left_q != '0);
endmodule

// File: rtl/seizure_trigger.sv
// Magnitude and PLV seizure trigger, top level.
// A magnitude comparator and a PLV window feed two retriggerable hold timers
// that share the duration sop_len + sph_len. The combined alarm is the AND of
// the two held alarms. Assumes tick is a single-clock pulse per sample.
module seizure_trigger
    import seizure_trig_pkg::*;
#(
    parameter int VAL_W    = VAL_W_DEF,
    parameter int HOLD_W   = HOLD_W_DEF,
    parameter int MAX_LOG2 = MAX_LOG2_DEF,
    parameter int LOG2_W   = LOG2_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [VAL_W-1:0]  mag_a,
    input  logic [VAL_W-1:0]  mag_b,
    input  logic [VAL_W-1:0]  plv,
    input  logic [VAL_W-1:0]  mag_a_thr,
    input  logic [VAL_W-1:0]  mag_b_thr,
    input  logic [VAL_W-1:0]  plv_thr,
    input  logic [LOG2_W-1:0] win_log2,
    input  logic [HOLD_W-1:0] sop_len,
    input  logic [HOLD_W-1:0] sph_len,
    output logic              mag_alarm,
    output logic              plv_alarm,
    output logic              comb_alarm
);
    localparam int DUR_W = HOLD_W + 1;

    logic [NUM_DET-1:0] det_trig;
    logic [NUM_DET-1:0] det_active;
    logic [DUR_W-1:0]   hold_dur;

    // Hold length without wrap-around.
    always_comb hold_dur = {1'b0, sop_len} + {1'b0, sph_len};

    dual_mag_compare #(.VAL_W(VAL_W)) u_mag (
        .tick  (tick),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .thr_a (mag_a_thr),
        .thr_b (mag_b_thr),
        .trig  (det_trig[DET_MAG])
    );

    plv_window #(.VAL_W(VAL_W), .MAX_LOG2(MAX_LOG2), .LOG2_W(LOG2_W)) u_plv (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .plv      (plv),
        .plv_thr  (plv_thr),
        .win_log2 (win_log2),
        .trig     (det_trig[DET_PLV])
    );

    // One hold timer per detector path.
    for (genvar g = 0; g < NUM_DET; g++) begin : g_hold
        hold_timer #(.DUR_W(DUR_W)) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .trig   (det_trig[g]),
            .dur    (hold_dur),
            .active (det_active[g])
        );
    end

    // Output mapping and the combined decision.
    always_comb begin
        mag_alarm  = det_active[DET_MAG];
        plv_alarm  = det_active[DET_PLV];
        comb_alarm = det_active[DET_MAG] && det_active[DET_PLV];
    end
endmodule

// File: rtl/seizure_trigger_chk.sv
// Assertion checker for seizure_trigger. It is attached to the top module by bind.
module seizure_trigger_chk #(
    parameter int VAL_W  = 10,
    parameter int HOLD_W = 24,
    parameter int LOG2_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [VAL_W-1:0]  mag_a,
    input logic [VAL_W-1:0]  mag_b,
    input logic [VAL_W-1:0]  mag_a_thr,
    input logic [VAL_W-1:0]  mag_b_thr,
    input logic [HOLD_W-1:0] sop_len,
    input logic [HOLD_W-1:0] sph_len,
    input logic              mag_alarm,
    input logic              plv_alarm,
    input logic              comb_alarm
);
    AST_MAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mag_alarm) |-> $past(tick && (mag_a > mag_a_thr) && (mag_b > mag_b_thr))); // R1
    AST_MAG_TRIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (mag_a > mag_a_thr) && (mag_b > mag_b_thr) && (sop_len != '0 || sph_len != '0))
        |=> mag_alarm); // R4
    AST_PLV_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(plv_alarm) |-> $past(tick)); // R2
    AST_COMB_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        comb_alarm |-> (mag_alarm && plv_alarm)); // R3
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && rst_n) |=> ($stable(mag_alarm) && $stable(plv_alarm))); // R5
endmodule

bind seizure_trigger seizure_trigger_chk #(
    .VAL_W(VAL_W), .HOLD_W(HOLD_W), .LOG2_W(LOG2_W)
) u_chk (.*);

// File: tb/seizure_trigger_test.sv
`timescale 1ns/1ps
module seizure_trigger_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [9:0]  mag_a = '0, mag_b = '0, plv = '0;
    logic [9:0]  mag_a_thr = '0, mag_b_thr = '0, plv_thr = '0;
    logic [2:0]  win_log2 = '0;
    logic [23:0] sop_len = '0, sph_len = '0;
    logic        mag_alarm, plv_alarm, comb_alarm;
    int          n_run = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    seizure_trigger uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .mag_a(mag_a), .mag_b(mag_b), .plv(plv),
        .mag_a_thr(mag_a_thr), .mag_b_thr(mag_b_thr), .plv_thr(plv_thr),
        .win_log2(win_log2), .sop_len(sop_len), .sph_len(sph_len),
        .mag_alarm(mag_alarm), .plv_alarm(plv_alarm), .comb_alarm(comb_alarm)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; tick = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic tk(input int a, input int b, input int p);
        @(negedge clk);
        mag_a = 10'(a); mag_b = 10'(b); plv = 10'(p); tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(mag_alarm, 1'b0, "R7 mag after reset");
        chk(plv_alarm, 1'b0, "R7 plv after reset");
        chk(comb_alarm, 1'b0, "R7 comb after reset");
        mag_a_thr = 10; mag_b_thr = 10; sop_len = 5; sph_len = 5;
        tk(20, 20, 1023);
        chk(mag_alarm, 1'b1, "R7 alarm set before reset");
        do_reset();
        chk(mag_alarm, 1'b0, "R7 reset clears held alarm");
    endtask

    task automatic t_mag();
        do_reset();
        mag_a_thr = 300; mag_b_thr = 400; sop_len = 1; sph_len = 2;
        plv_thr = 0; win_log2 = 0;
        tk(301, 401, 0);
        chk(mag_alarm, 1'b1, "R1 both above");
        tk(0, 0, 0); tk(0, 0, 0);
        chk(mag_alarm, 1'b1, "R4 held after D-1 ticks");
        tk(0, 0, 0);
        chk(mag_alarm, 1'b0, "R4 released on D-th tick");
        tk(300, 500, 0);
        chk(mag_alarm, 1'b0, "R1 equal A no trigger");
        tk(500, 400, 0);
        chk(mag_alarm, 1'b0, "R1 equal B no trigger");
        tk(301, 100, 0);
        chk(mag_alarm, 1'b0, "R1 one channel only");
    endtask

    task automatic t_zero_dur();
        do_reset();
        mag_a_thr = 0; mag_b_thr = 0; sop_len = 0; sph_len = 0;
        tk(1023, 1023, 1023);
        chk(mag_alarm, 1'b0, "R4 zero duration no alarm");
    endtask

    task automatic t_no_tick();
        do_reset();
        mag_a_thr = 10; mag_b_thr = 10; sop_len = 1; sph_len = 0;
        @(negedge clk); mag_a = 100; mag_b = 100;
        repeat (5) @(negedge clk);
        chk(mag_alarm, 1'b0, "R5 no trigger without tick");
        tk(100, 100, 1023);
        repeat (20) @(negedge clk);
        chk(mag_alarm, 1'b1, "R5 hold frozen without tick");
        tk(0, 0, 1023);
        chk(mag_alarm, 1'b0, "R4 D=1 released on next tick");
    endtask

    task automatic t_retrig();
        do_reset();
        mag_a_thr = 10; mag_b_thr = 10; sop_len = 2; sph_len = 1;
        tk(50, 50, 1023);
        tk(0, 0, 1023);
        tk(50, 50, 1023);
        tk(0, 0, 1023); tk(0, 0, 1023);
        chk(mag_alarm, 1'b1, "R6 reloaded hold still active");
        tk(0, 0, 1023);
        chk(mag_alarm, 1'b0, "R6 reloaded hold ends after full D");
    endtask

    task automatic t_plv();
        do_reset();
        mag_a_thr = 1023; mag_b_thr = 1023;
        win_log2 = 2; plv_thr = 500; sop_len = 2; sph_len = 0;
        tk(0, 0, 400); tk(0, 0, 400); tk(0, 0, 400);
        chk(plv_alarm, 1'b0, "R2 no trigger inside window");
        tk(0, 0, 400);
        chk(plv_alarm, 1'b1, "R2 low window sum triggers");
        tk(0, 0, 600);
        chk(plv_alarm, 1'b1, "R4 plv held");
        tk(0, 0, 600);
        chk(plv_alarm, 1'b0, "R4 plv released");
        tk(0, 0, 600); tk(0, 0, 600);
        chk(plv_alarm, 1'b0, "R2 high window sum no trigger");
        tk(0, 0, 500); tk(0, 0, 500); tk(0, 0, 500); tk(0, 0, 500);
        chk(plv_alarm, 1'b0, "R2 sum equal to limit no trigger");
        tk(0, 0, 499); tk(0, 0, 500); tk(0, 0, 500); tk(0, 0, 500);
        chk(plv_alarm, 1'b1, "R2 sum one below limit triggers");
        do_reset();
        win_log2 = 0; plv_thr = 100;
        tk(0, 0, 99);
        chk(plv_alarm, 1'b1, "R2 single-sample window below");
        do_reset();
        tk(0, 0, 100);
        chk(plv_alarm, 1'b0, "R2 single-sample window equal");
    endtask

    task automatic t_comb();
        do_reset();
        mag_a_thr = 100; mag_b_thr = 100;
        win_log2 = 2; plv_thr = 500; sop_len = 3; sph_len = 0;
        tk(0, 0, 0); tk(0, 0, 0); tk(0, 0, 0);
        chk(comb_alarm, 1'b0, "R3 comb idle");
        tk(200, 200, 0);
        chk(mag_alarm, 1'b1, "R1 same-tick mag");
        chk(plv_alarm, 1'b1, "R2 same-tick plv");
        chk(comb_alarm, 1'b1, "R3 comb rises with both");
        tk(200, 200, 1023);
        chk(comb_alarm, 1'b1, "R3 comb while both held");
        tk(0, 0, 1023); tk(0, 0, 1023);
        chk(plv_alarm, 1'b0, "R4 plv hold over");
        chk(mag_alarm, 1'b1, "R6 mag still held");
        chk(comb_alarm, 1'b0, "R3 comb falls with plv");
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_mag();
        t_zero_dur();
        t_no_tick();
        t_retrig();
        t_plv();
        t_comb();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule